// File: doc/BRIEF.md
# Replacement Way Picker with Deferred Copyback

This block chooses which way of a set-associative data cache is replaced on a miss. For the indexed set it takes per-way valid, modified, lock and age state. Among the ways that are not locked it picks the one with the greatest age. When that way holds modified-valid data, the block saves the line address and its four data words in a one-entry copyback buffer. The write of that line to memory waits until the fetch of the missing line has finished.

When the line-fill engine signals completion, the buffer drains as a four-beat burst write. Each beat waits for a bus acknowledge. An error returned on any beat raises a one-cycle machine-check pulse. That pulse is imprecise: it is not tied to the access that caused the miss. The drain then goes on to the last beat. While the buffer is valid, a debug port can read its contents. The block starts one fill at a time. A miss whose victim is dirty waits while the buffer is still occupied. A miss whose victim is clean overwrites the old line and does not use the buffer.

Top module: `cbv_victim_copyback`

## Requirements
- R1: With `miss_req` high, `sel_way` is the unlocked way with the largest age field. Way i's age is `way_age[i*AGEW +: AGEW]`, and a larger value means less recently used. When ages tie, the lowest index wins.
- R2: A way whose `way_lock` bit is set is never granted: `fill_start` is never high with `sel_way` pointing at a locked way.
- R3: A granted victim whose valid and modified bits are both 1 is captured on the grant edge. From the next cycle, `dbg_valid` is 1, `dbg_addr` equals the `vic_addr` given at the grant, and beat k holds `vic_data[k*DW +: DW]`. A victim that is clean or invalid leaves `dbg_valid` at 0.
- R4: A captured line raises `wb_req` only in the first cycle after a `fill_done` pulse that follows its capture. Before that pulse, `wb_req` stays 0 however long it waits.
- R5: The drain sends beats 0, 1, 2 and 3 in that order. Each beat shows `wb_addr` (the captured line address), `wb_beat` (the beat index) and `wb_data` (that word). A beat is held stable until `wb_ack` is high at a clock edge.
- R6: If every way of the set is locked, `no_victim` is 1 while `miss_req` is high, and `fill_start` stays 0.
- R7: A miss whose victim is dirty is held (`fill_start` 0) while the buffer is valid. A miss whose victim is clean may still be granted in that time.
- R8: The buffer's valid state (`dbg_valid`) clears in the cycle after beat 3 is acknowledged.
- R9: A beat acknowledged with `wb_err` high makes `mchk` high for exactly the following cycle. The remaining beats are still sent.
- R10: While `dbg_valid` is 1, `dbg_word` shows the buffered word selected by `dbg_sel`, combinationally.
- R11: After `fill_start`, no further fill starts until `fill_done` has been seen at a clock edge.
- R12: After reset, `fill_start`, `no_victim`, `wb_req`, `mchk` and `dbg_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_req | input | 1 | Miss wants a victim; held until granted |
| way_valid | input | WAYS | Per-way valid bits of the indexed set |
| way_dirty | input | WAYS | Per-way modified bits |
| way_lock | input | WAYS | Per-way lock bits |
| way_age | input | WAYS*AGEW | Per-way age fields, larger is older |
| vic_addr | input | AW | Line address of the way on `sel_way` |
| vic_data | input | WORDS*DW | Data words of the way on `sel_way` |
| fill_done | input | 1 | Pulse: the requested line has been fetched |
| fill_start | output | 1 | Grant: fill may begin into `sel_way` |
| sel_way | output | WAYW | Chosen victim way |
| no_victim | output | 1 | Every way in the set is locked |
| wb_req | output | 1 | Copyback beat is offered |
| wb_addr | output | AW | Line address of the copyback |
| wb_beat | output | BW | Beat index of the offered word |
| wb_data | output | DW | Offered data word |
| wb_ack | input | 1 | Bus accepts the offered beat |
| wb_err | input | 1 | Bus error on the acknowledged beat |
| mchk | output | 1 | Imprecise machine-check pulse |
| dbg_sel | input | BW | Debug word select |
| dbg_valid | output | 1 | Copyback buffer holds a line |
| dbg_addr | output | AW | Buffered line address |
| dbg_word | output | DW | Buffered word chosen by `dbg_sel` |

## Verification
Several rules are checked by assertions on every cycle:
- a locked way is never granted;
- no fill starts while the set has no victim;
- fills never start back to back;
- a burst begins only right after a fill completion;
- beats hold steady until acknowledged;
- the buffer empties after the last beat;
- the machine-check pulse follows an erroring acknowledge.

Other behaviours need the bench's scenarios: the age ordering with ties and locks, the captured words, the beat order with errors mid-burst, and the difference between dirty stalls and clean grants while a copyback is waiting. The bench checks these against a queue of expected beats.

// File: rtl/cbv_pkg.sv
package cbv_pkg;
  typedef enum logic [1:0] {
    CB_EMPTY = 2'd0,
    CB_HELD  = 2'd1,
    CB_DRAIN = 2'd2
  } cb_state_e;
endpackage

// File: rtl/cbv_victim_pick.sv
module cbv_victim_pick #(
  parameter int WAYS = 4,
  parameter int AGEW = 2,
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [WAYS-1:0]      way_lock,
  input  logic [WAYS*AGEW-1:0] way_age,
  output logic [WAYW-1:0]      pick_way,
  output logic                 pick_found
);
  // Oldest unlocked way; strict compare keeps the lowest index on ties.
  function automatic logic [WAYW:0] oldest_unlocked(
    input logic [WAYS-1:0]      lk,
    input logic [WAYS*AGEW-1:0] ages
  );
    logic            f;
    logic [WAYW-1:0] w;
    logic [AGEW-1:0] best;
    f    = 1'b0;
    w    = '0;
    best = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (!lk[i] && (!f || ages[i*AGEW +: AGEW] > best)) begin
        f    = 1'b1;
        w    = WAYW'(i);
        best = ages[i*AGEW +: AGEW];
      end
    end
    return {f, w};
  endfunction

  always_comb begin
    {pick_found, pick_way} = oldest_unlocked(way_lock, way_age);
  end
endmodule

// File: rtl/cbv_copyback_buf.sv
module cbv_copyback_buf
  import cbv_pkg::*;
#(
  parameter int AW    = 28,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int BW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               capture,
  input  logic [AW-1:0]      cap_addr,
  input  logic [WORDS*DW-1:0] cap_data,
  input  logic               fill_seen,
  input  logic               wb_ack,
  input  logic               wb_err,
  input  logic [BW-1:0]      dbg_sel,
  output logic               buf_valid,
  output logic               wb_req,
  output logic [AW-1:0]      wb_addr,
  output logic [BW-1:0]      wb_beat,
  output logic [DW-1:0]      wb_data,
  output logic               wb_last,
  output logic               mchk,
  output logic [DW-1:0]      dbg_word
);
  cb_state_e       state;
  logic [AW-1:0]   line_addr;
  logic [DW-1:0]   words [WORDS];
  logic [BW-1:0]   beat;
  logic            beat_done;

  assign buf_valid = (state != CB_EMPTY);
  assign wb_req    = (state == CB_DRAIN);
  assign wb_addr   = line_addr;
  assign wb_beat   = beat;
  assign wb_data   = words[beat];
  assign wb_last   = (beat == BW'(WORDS-1));
  assign beat_done = wb_req && wb_ack;
  assign dbg_word  = words[dbg_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= CB_EMPTY;
      beat  <= '0;
      mchk  <= 1'b0;
    end else begin
      mchk <= beat_done && wb_err;
      unique case (state)
        CB_EMPTY: if (capture) begin
          state <= CB_HELD;
          beat  <= '0;
        end
        CB_HELD: if (fill_seen) state <= CB_DRAIN;
        CB_DRAIN: if (beat_done) begin
          if (wb_last) begin
            state <= CB_EMPTY;
            beat  <= '0;
          end else begin
            beat <= beat + 1'b1;
          end
        end
        default: state <= CB_EMPTY;
      endcase
    end
  end

  generate
    for (genvar k = 0; k < WORDS; k++) begin : g_word
      always_ff @(posedge clk) begin
        if (capture && state == CB_EMPTY) words[k] <= cap_data[k*DW +: DW];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (capture && state == CB_EMPTY) line_addr <= cap_addr;
  end

  p_clear_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack && wb_last) |=> !buf_valid);
  p_beat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_beat) && $stable(wb_addr)));
  p_mchk_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mchk |-> $past(wb_req && wb_ack && wb_err));
endmodule

// File: rtl/cbv_victim_copyback.sv
module cbv_victim_copyback #(
  parameter int WAYS  = 4,
  parameter int AGEW  = 2,
  parameter int AW    = 28,
  parameter int DW    = 32,
  parameter int WORDS = 4,
  localparam int WAYW = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int BW   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miss_req,
  input  logic [WAYS-1:0]     way_valid,
  input  logic [WAYS-1:0]     way_dirty,
  input  logic [WAYS-1:0]     way_lock,
  input  logic [WAYS*AGEW-1:0] way_age,
  input  logic [AW-1:0]       vic_addr,
  input  logic [WORDS*DW-1:0] vic_data,
  input  logic                fill_done,
  output logic                fill_start,
  output logic [WAYW-1:0]     sel_way,
  output logic                no_victim,
  output logic                wb_req,
  output logic [AW-1:0]       wb_addr,
  output logic [BW-1:0]       wb_beat,
  output logic [DW-1:0]       wb_data,
  input  logic                wb_ack,
  input  logic                wb_err,
  output logic                mchk,
  input  logic [BW-1:0]       dbg_sel,
  output logic                dbg_valid,
  output logic [AW-1:0]       dbg_addr,
  output logic [DW-1:0]       dbg_word
);
  logic pick_found;
  logic vic_dirty;
  logic fill_pend;
  logic fill_seen;
  logic capture;
  logic buf_valid;
  logic wb_last;

  cbv_victim_pick #(.WAYS(WAYS), .AGEW(AGEW)) u_pick (
    .way_lock   (way_lock),
    .way_age    (way_age),
    .pick_way   (sel_way),
    .pick_found (pick_found)
  );

  assign vic_dirty  = way_valid[sel_way] && way_dirty[sel_way];
  assign fill_start = miss_req && !fill_pend && pick_found && !(vic_dirty && buf_valid);
  assign no_victim  = miss_req && !pick_found;
  assign capture    = fill_start && vic_dirty;
  assign fill_seen  = fill_done && fill_pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fill_pend <= 1'b0;
    else if (fill_start) fill_pend <= 1'b1;
    else if (fill_seen)  fill_pend <= 1'b0;
  end

  cbv_copyback_buf #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .cap_addr  (vic_addr),
    .cap_data  (vic_data),
    .fill_seen (fill_seen),
    .wb_ack    (wb_ack),
    .wb_err    (wb_err),
    .dbg_sel   (dbg_sel),
    .buf_valid (buf_valid),
    .wb_req    (wb_req),
    .wb_addr   (wb_addr),
    .wb_beat   (wb_beat),
    .wb_data   (wb_data),
    .wb_last   (wb_last),
    .mchk      (mchk),
    .dbg_word  (dbg_word)
  );

  assign dbg_valid = buf_valid;
  assign dbg_addr  = wb_addr;

  p_never_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |-> !way_lock[sel_way]);
  p_no_victim_no_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    no_victim |-> !fill_start);
  p_single_fill_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start |=> !fill_start);
  p_drain_after_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wb_req) |-> $past(fill_done));
  p_capture_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (dbg_valid && dbg_addr == $past(vic_addr)));
endmodule

// File: tb/cbv_victim_copyback_bench.sv
`timescale 1ns/1ps
module cbv_victim_copyback_bench;
  localparam int WAYS = 4, AGEW = 2, AW = 28, DW = 32, WORDS = 4;
  localparam int WAYW = 2, BW = 2;

  logic clk = 0, rst_n = 0;
  logic miss_req = 0;
  logic [WAYS-1:0] way_valid = 0, way_dirty = 0, way_lock = 0;
  logic [WAYS*AGEW-1:0] way_age = 0;
  logic [AW-1:0] vic_addr = 0;
  logic [WORDS*DW-1:0] vic_data = 0;
  logic fill_done = 0, wb_ack = 0, wb_err = 0;
  logic [BW-1:0] dbg_sel = 0;
  logic fill_start, no_victim, wb_req, mchk, dbg_valid;
  logic [WAYW-1:0] sel_way;
  logic [AW-1:0] wb_addr, dbg_addr;
  logic [BW-1:0] wb_beat;
  logic [DW-1:0] wb_data, dbg_word;

  cbv_victim_copyback u_cbv_victim_copyback (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [AW+BW+DW-1:0] exp_q [$];
  bit ack_en = 1, err_arm = 0;
  logic [BW-1:0] err_beat = 0;
  bit prev_err = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [WAYS*AGEW-1:0] ages(int a0, int a1, int a2, int a3);
    return {AGEW'(a3), AGEW'(a2), AGEW'(a1), AGEW'(a0)};
  endfunction

  function automatic logic [WORDS*DW-1:0] line_of(logic [15:0] seed);
    logic [WORDS*DW-1:0] d;
    for (int k = 0; k < WORDS; k++) d[k*DW +: DW] = {seed, 16'(k * 16'h1111 + 16'h0a05)};
    return d;
  endfunction

  // Acker and monitor: acks every other cycle, compares beats against the queue.
  always @(negedge clk) begin
    if (prev_err || mchk) chk("R9 mchk pulse", 64'(mchk), 64'(prev_err));
    prev_err = 0;
    if (ack_en && wb_req && !wb_ack) begin
      if (exp_q.size() == 0) chk("R5 unexpected beat", 64'(wb_req), 64'd0);
      else begin
        logic [AW+BW+DW-1:0] e;
        e = exp_q.pop_front();
        chk("R5 beat addr", 64'(wb_addr), 64'(e[AW+BW+DW-1 -: AW]));
        chk("R5 beat index", 64'(wb_beat), 64'(e[DW +: BW]));
        chk("R5 beat data", 64'(wb_data), 64'(e[DW-1:0]));
      end
      wb_ack = 1;
      wb_err = err_arm && (wb_beat == err_beat);
      prev_err = wb_err;
    end else begin
      wb_ack = 0;
      wb_err = 0;
    end
  end

  task automatic miss(string tag, logic [3:0] v, logic [3:0] d, logic [3:0] l,
                      logic [WAYS*AGEW-1:0] ag, logic [AW-1:0] a, logic [WORDS*DW-1:0] dat,
                      bit exp_start, int exp_way, bit push);
    @(negedge clk);
    way_valid = v; way_dirty = d; way_lock = l; way_age = ag;
    vic_addr = a; vic_data = dat; miss_req = 1;
    #1;
    chk({tag, " fill_start"}, 64'(fill_start), 64'(exp_start));
    if (exp_start) chk({tag, " sel_way"}, 64'(sel_way), 64'(exp_way));
    if (exp_start && push)
      for (int k = 0; k < WORDS; k++) exp_q.push_back({a, BW'(k), dat[k*DW +: DW]});
    @(negedge clk);
    miss_req = 0;
  endtask

  task automatic pulse_fill();
    @(negedge clk); fill_done = 1;
    @(negedge clk); fill_done = 0;
  endtask

  task automatic wait_drain();
    for (int i = 0; i < 200 && dbg_valid; i++) @(negedge clk);
    chk("R8 buffer empty after last beat", 64'(dbg_valid), 64'd0);
    chk("R5 all beats seen", 64'(exp_q.size()), 64'd0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 fill_start", 64'(fill_start), 0);
    chk("R12 wb_req", 64'(wb_req), 0);
    chk("R12 dbg_valid", 64'(dbg_valid), 0);
    chk("R12 mchk", 64'(mchk), 0);
    rst_n = 1;
    @(negedge clk);
    chk("R12 no_victim", 64'(no_victim), 0);

    // R1 oldest way, clean victim bypasses buffer (R3)
    miss("R1 oldest", 4'hF, 4'h0, 4'h0, ages(0, 3, 1, 2), 28'h10, line_of(16'h1), 1, 1, 0);
    chk("R3 clean bypass", 64'(dbg_valid), 0);
    // R11 no second fill while one pending
    miss("R11 pending", 4'hF, 4'h0, 4'h0, ages(0, 3, 1, 2), 28'h11, line_of(16'h1), 0, 0, 0);
    pulse_fill();
    miss("R1 tie lowest", 4'hF, 4'h0, 4'h0, ages(2, 2, 2, 2), 28'h12, line_of(16'h2), 1, 0, 0);
    pulse_fill();
    miss("R2 skip locked", 4'hF, 4'h0, 4'h2, ages(0, 3, 2, 2), 28'h13, line_of(16'h3), 1, 2, 0);
    pulse_fill();
    // R6 all locked
    @(negedge clk);
    way_lock = 4'hF; miss_req = 1; #1;
    chk("R6 no_victim", 64'(no_victim), 1);
    chk("R6 no fill", 64'(fill_start), 0);
    @(negedge clk); miss_req = 0; way_lock = 0;

    // Dirty victim held until fill completes
    ack_en = 0;
    miss("R3 dirty grant", 4'hF, 4'h4, 4'h0, ages(0, 1, 3, 2), 28'hABCDE, line_of(16'hBEEF), 1, 2, 1);
    chk("R3 captured", 64'(dbg_valid), 1);
    chk("R3 addr", 64'(dbg_addr), 64'h0ABCDE);
    for (int k = 0; k < WORDS; k++) begin
      dbg_sel = BW'(k); #1;
      chk("R10 debug word", 64'(dbg_word), 64'(line_of(16'hBEEF) >> (k*DW)) & 64'hFFFF_FFFF);
    end
    repeat (5) @(negedge clk);
    chk("R4 no drain before fill", 64'(wb_req), 0);
    @(negedge clk); fill_done = 1;
    @(negedge clk); fill_done = 0;
    chk("R4 drain right after fill", 64'(wb_req), 1);
    miss("R7 dirty stalls", 4'hF, 4'h1, 4'h0, ages(3, 0, 0, 0), 28'h222, line_of(16'h2222), 0, 0, 0);
    miss("R7 clean proceeds", 4'hF, 4'h0, 4'h0, ages(0, 3, 0, 0), 28'h333, line_of(16'h3), 1, 1, 0);
    pulse_fill();
    ack_en = 1;
    wait_drain();

    // Error mid-burst: mchk pulse, drain continues
    err_arm = 1; err_beat = 2'd1;
    miss("R9 dirty grant", 4'hF, 4'h8, 4'h0, ages(0, 0, 0, 3), 28'h5A5A5, line_of(16'h7777), 1, 3, 1);
    pulse_fill();
    wait_drain();
    err_arm = 0;
    repeat (3) @(negedge clk);
    chk("R9 mchk quiet", 64'(mchk), 0);
    finish_run();
  end
endmodule